// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block models the command interface of a byte-wide firmware flash device, as seen from the device side of a simple synchronous bus. A host writes command bytes with a write strobe and reads back data with a read strobe. Depending on the last command, a read returns array contents, identification and lock information, or an 8-bit status byte. Erase, program and lock-release operations need a setup write followed by a second write. Each operation then holds the device busy for a fixed, parameterised number of cycles. The operation takes effect on the internal array or the lock bits only when that busy time ends.

The storage is a small register array split into equal blocks. Each block has its own write-protect bit, and every block comes out of reset protected. A master lockdown input decides whether the block protection may be released. Errors are kept in sticky status flags until the host clears them. A setup write that is not followed by the confirm byte is reported as an error, and so is an attempt to modify a protected block.

Top module: `flashCmdTop`

## Requirements
- R1: After reset the device is in array-read mode, every byte of the array reads 0xFF, every block is protected, and the status byte is 0x80.
- R2: Writing 0xFF selects array-read mode. A read then returns the array byte at the address, one cycle after the read strobe.
- R3: Writing 0x90 selects identifier mode. Address 0 reads the manufacturer code and address 1 reads the device code. Address 3 reads 0x01 when the lockdown input is high and 0x00 when it is low. Any block base + 2 reads 0x01 when that block is protected and 0x00 when it is not.
- R4: Writing 0x70 selects status-read mode. Status bit 7 is 1 when ready and 0 while an operation runs, and an operation keeps it at 0 for BUSY_CYCLES cycles. Bit 5 flags an erase error, bit 4 a program error and bit 1 a protection error. Bits 6, 3 and 2 always read 0.
- R5: Writing 0x50 clears status bits 5, 4 and 1 and leaves the read mode unchanged.
- R6: The write pair 0x20 then 0xD0, with the confirm at any address in an unprotected block, sets every byte of that block to 0xFF. The other blocks are not changed.
- R7: The write pair 0x40 then a data write to an unprotected block changes that byte to old AND data.
- R8: The write pair 0x60 then 0xD0 releases the protection of every block when the lockdown input is low. When the lockdown input is high it sets status bit 1, and every block stays protected.
- R9: An erase or lock-release setup followed by any byte other than 0xD0 sets status bits 5 and 4 and changes neither the array nor the lock bits.
- R10: An erase or program aimed at a protected block sets status bit 1 and leaves the array unchanged.
- R11: After the second write of an erase, program or lock-release sequence the device is in status-read mode. This holds whether or not the operation started.
- R12: Writes made while an operation is running are ignored, including a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| rdEn | input | 1 | Read strobe; data appears on rdData the next cycle |
| addr | input | ADDR_W | Byte address for reads and writes |
| wrData | input | 8 | Command or data byte |
| masterLock | input | 1 | Lockdown input; high forbids releasing block protection |
| rdData | output | 8 | Registered read data |

## Verification
The bench first tries to modify protected blocks and checks that the array is unchanged and that only bit 1 is raised. A design that tested protection at the setup write, or not at all, would corrupt the array or flag the wrong bit. An aborted setup must raise both erase and program error bits, and a design that treated any second byte as a confirm would erase the block. Programming twice checks the AND behaviour, which a plain write would miss. Erasing one block after another block was programmed shows whether the block decode is wrong. A mode-change write made during the busy time must leave the device reading status afterwards, which shows whether a design accepts writes while busy.

// File: rtl/flashCmdPkg.sv
package flashCmdPkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_ID     = 2'd1,
    MODE_STATUS = 2'd2
  } readMode_e;

  // strobes from control to datapath, each active for one cycle at op end
  typedef struct packed {
    logic eraseGo;
    logic progGo;
    logic lockClrGo;
  } dpStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_READ_ID      = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
  localparam logic [7:0] CMD_UNLOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_CONFIRM      = 8'hD0;

endpackage

// File: rtl/flashCmdCtrl.sv
module flashCmdCtrl
  import flashCmdPkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BLOCK_W     = 4,
  parameter int BUSY_CYCLES = 8,
  localparam int NUM_BLOCKS = 1 << (ADDR_W - BLOCK_W),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            wrData,
  input  logic                  masterLock,
  input  logic [NUM_BLOCKS-1:0] lockBits,
  output readMode_e             mode,
  output logic [7:0]            statusByte,
  output dpStrobe_t             strb,
  output logic [ADDR_W-1:0]     opAddr,
  output logic [7:0]            opData,
  output logic                  busy,
  output logic                  cmdIdle
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE_SETUP, ST_PROG_SETUP, ST_UNLOCK_SETUP, ST_BUSY
  } cmdState_e;

  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_UNLOCK} opKind_e;

  cmdState_e  state;
  opKind_e    opKind;
  logic [CNT_W-1:0] cnt;
  logic       eraseErr, progErr, lockErr;
  logic       blkLocked;

  assign blkLocked = lockBits[addr[ADDR_W-1:BLOCK_W]];
  assign busy      = (state == ST_BUSY);
  assign cmdIdle   = (state == ST_IDLE);
  assign statusByte = {!busy, 1'b0, eraseErr, progErr, 1'b0, 1'b0, lockErr, 1'b0};

  always_comb begin
    strb = '0;
    if (state == ST_BUSY && cnt == '0) begin
      strb.eraseGo   = (opKind == OP_ERASE);
      strb.progGo    = (opKind == OP_PROG);
      strb.lockClrGo = (opKind == OP_UNLOCK);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      mode     <= MODE_ARRAY;
      opKind   <= OP_ERASE;
      cnt      <= '0;
      opAddr   <= '0;
      opData   <= '0;
      eraseErr <= 1'b0;
      progErr  <= 1'b0;
      lockErr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (wrEn) begin
          case (wrData)
            CMD_READ_ARRAY:   mode  <= MODE_ARRAY;
            CMD_READ_ID:      mode  <= MODE_ID;
            CMD_READ_STATUS:  mode  <= MODE_STATUS;
            CMD_CLEAR_STATUS: begin
              eraseErr <= 1'b0;
              progErr  <= 1'b0;
              lockErr  <= 1'b0;
            end
            CMD_ERASE_SETUP:  state <= ST_ERASE_SETUP;
            CMD_PROG_SETUP:   state <= ST_PROG_SETUP;
            CMD_UNLOCK_SETUP: state <= ST_UNLOCK_SETUP;
            default: ;
          endcase
        end
        ST_ERASE_SETUP: if (wrEn) begin
          mode  <= MODE_STATUS;
          state <= ST_IDLE;
          if (wrData != CMD_CONFIRM) begin
            eraseErr <= 1'b1;
            progErr  <= 1'b1;
          end else if (blkLocked) begin
            lockErr <= 1'b1;
          end else begin
            state  <= ST_BUSY;
            opKind <= OP_ERASE;
            opAddr <= addr;
            cnt    <= CNT_W'(BUSY_CYCLES - 1);
          end
        end
        ST_PROG_SETUP: if (wrEn) begin
          mode  <= MODE_STATUS;
          state <= ST_IDLE;
          if (blkLocked) begin
            lockErr <= 1'b1;
          end else begin
            state  <= ST_BUSY;
            opKind <= OP_PROG;
            opAddr <= addr;
            opData <= wrData;
            cnt    <= CNT_W'(BUSY_CYCLES - 1);
          end
        end
        ST_UNLOCK_SETUP: if (wrEn) begin
          mode  <= MODE_STATUS;
          state <= ST_IDLE;
          if (wrData != CMD_CONFIRM) begin
            eraseErr <= 1'b1;
            progErr  <= 1'b1;
          end else if (masterLock) begin
            lockErr <= 1'b1;
          end else begin
            state  <= ST_BUSY;
            opKind <= OP_UNLOCK;
            cnt    <= CNT_W'(BUSY_CYCLES - 1);
          end
        end
        ST_BUSY: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashCmdDatapath.sv
module flashCmdDatapath
  import flashCmdPkg::*;
#(
  parameter int ADDR_W          = 6,
  parameter int BLOCK_W         = 4,
  parameter logic [7:0] MFR_CODE = 8'hA7,
  parameter logic [7:0] DEV_CODE = 8'h3C,
  localparam int NUM_BLOCKS     = 1 << (ADDR_W - BLOCK_W),
  localparam int MEM_DEPTH      = 1 << ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  masterLock,
  input  readMode_e             mode,
  input  logic [7:0]            statusByte,
  input  dpStrobe_t             strb,
  input  logic [ADDR_W-1:0]     opAddr,
  input  logic [7:0]            opData,
  output logic [NUM_BLOCKS-1:0] lockBits,
  output logic [7:0]            rdData
);

  logic [7:0] mem [MEM_DEPTH];
  logic [7:0] idByte;
  logic [ADDR_W-BLOCK_W-1:0] opBlock;

  assign opBlock = opAddr[ADDR_W-1:BLOCK_W];

  always_ff @(posedge clk) begin
    for (int i = 0; i < MEM_DEPTH; i++) begin
      if (!rstN)
        mem[i] <= 8'hFF;
      else if (strb.eraseGo && (i >> BLOCK_W) == int'(opBlock))
        mem[i] <= 8'hFF;
      else if (strb.progGo && i == int'(opAddr))
        mem[i] <= mem[i] & opData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               lockBits <= '1;
    else if (strb.lockClrGo) lockBits <= '0;
  end

  always_comb begin
    if (addr == ADDR_W'(0))
      idByte = MFR_CODE;
    else if (addr == ADDR_W'(1))
      idByte = DEV_CODE;
    else if (addr == ADDR_W'(3))
      idByte = {7'b0, masterLock};
    else if (addr[BLOCK_W-1:0] == BLOCK_W'(2))
      idByte = {7'b0, lockBits[addr[ADDR_W-1:BLOCK_W]]};
    else
      idByte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= 8'h00;
    else if (rdEn) begin
      case (mode)
        MODE_ID:     rdData <= idByte;
        MODE_STATUS: rdData <= statusByte;
        default:     rdData <= mem[addr];
      endcase
    end
  end

endmodule

// File: rtl/flashCmdTop.sv
module flashCmdTop
  import flashCmdPkg::*;
#(
  parameter int ADDR_W           = 6,
  parameter int BLOCK_W          = 4,
  parameter int BUSY_CYCLES      = 8,
  parameter logic [7:0] MFR_CODE = 8'hA7,
  parameter logic [7:0] DEV_CODE = 8'h3C,
  localparam int NUM_BLOCKS      = 1 << (ADDR_W - BLOCK_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic              masterLock,
  output logic [7:0]        rdData
);

  readMode_e             mode;
  logic [7:0]            statusByte;
  dpStrobe_t             strb;
  logic [ADDR_W-1:0]     opAddr;
  logic [7:0]            opData;
  logic                  busy;
  logic                  cmdIdle;
  logic [NUM_BLOCKS-1:0] lockBits;

  flashCmdCtrl #(
    .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .masterLock(masterLock), .lockBits(lockBits), .mode(mode),
    .statusByte(statusByte), .strb(strb), .opAddr(opAddr), .opData(opData),
    .busy(busy), .cmdIdle(cmdIdle)
  );

  flashCmdDatapath #(
    .ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .masterLock(masterLock),
    .mode(mode), .statusByte(statusByte), .strb(strb), .opAddr(opAddr),
    .opData(opData), .lockBits(lockBits), .rdData(rdData)
  );

endmodule

// File: rtl/flashCmdChk.sv
module flashCmdChk
  import flashCmdPkg::*;
#(
  parameter int BUSY_CYCLES = 8,
  parameter int NUM_BLOCKS  = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [7:0]            wrData,
  input logic                  busy,
  input logic                  cmdIdle,
  input readMode_e             mode,
  input logic [7:0]            statusByte,
  input dpStrobe_t             strb,
  input logic [NUM_BLOCKS-1:0] lockBits
);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R4: busy never outlasts its configured length
  p_busy_bounded_r4: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= BUSY_CYCLES);

  // R5: clear-status wipes all error flags
  p_clear_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdIdle && wrData == CMD_CLEAR_STATUS) |=>
      (statusByte[5:4] == 2'b00 && statusByte[1] == 1'b0));

  // R8: protection can be released but never re-set after reset
  p_lock_only_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lockBits & ~$past(lockBits)) == '0);

  // R11: any operation starts with the device in status-read mode
  p_status_mode_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> mode == MODE_STATUS);

  // R12: a write during busy does not change the read mode
  p_busy_ignores_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn) |=> mode == $past(mode));

  // R12: at most one datapath operation fires at a time
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));

endmodule

bind flashCmdTop flashCmdChk #(
  .BUSY_CYCLES(BUSY_CYCLES), .NUM_BLOCKS(NUM_BLOCKS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .busy(busy),
  .cmdIdle(cmdIdle), .mode(mode), .statusByte(statusByte), .strb(strb),
  .lockBits(lockBits)
);

// File: tb/flashCmdTop_tb.sv
`timescale 1ns/1ps
module flashCmdTop_tb;

  localparam int ADDR_W = 6;
  localparam logic [7:0] MFR = 8'hA7;
  localparam logic [7:0] DEV = 8'h3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic masterLock = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flashCmdTop #(.ADDR_W(ADDR_W), .BLOCK_W(4), .BUSY_CYCLES(8),
                .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .masterLock(masterLock), .rdData(rdData));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic waitReady(input string req);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 40; i++) begin
      doRead('0, s);
      if (s[7]) break;
    end
    check(req, {7'b0, s[7]}, 8'h01);
  endtask

  task automatic testReset();
    logic [7:0] v;
    doRead(6'h05, v); check("R1 erased array", v, 8'hFF);
    doRead(6'h3E, v); check("R1 erased array top", v, 8'hFF);
    doWrite('0, 8'h70);
    doRead('0, v); check("R1/R4 reset status", v, 8'h80);
  endtask

  task automatic testIdent();
    logic [7:0] v;
    doWrite('0, 8'h90);
    doRead(6'h00, v); check("R3 manufacturer", v, MFR);
    doRead(6'h01, v); check("R3 device", v, DEV);
    doRead(6'h03, v); check("R3 lockdown low", v, 8'h00);
    doRead(6'h12, v); check("R3 block1 protected", v, 8'h01);
    masterLock = 1'b1;
    doRead(6'h03, v); check("R3 lockdown high", v, 8'h01);
    masterLock = 1'b0;
  endtask

  task automatic testProtected();
    logic [7:0] v;
    doWrite(6'h05, 8'h40);
    doWrite(6'h05, 8'h00);
    doRead('0, v); check("R10/R11 program protected status", v, 8'h82);
    doWrite('0, 8'h50);
    doRead('0, v); check("R5 clear keeps status mode", v, 8'h80);
    doWrite(6'h07, 8'h20);
    doWrite(6'h07, 8'hD0);
    doRead('0, v); check("R10 erase protected status", v, 8'h82);
    doWrite('0, 8'h50);
    doWrite('0, 8'hFF);
    doRead(6'h05, v); check("R10/R2 array unchanged", v, 8'hFF);
  endtask

  task automatic testAbort();
    logic [7:0] v;
    doWrite(6'h10, 8'h20);
    doWrite(6'h10, 8'h33);
    doRead('0, v); check("R9/R11 erase abort status", v, 8'hB0);
    doWrite('0, 8'h50);
    doWrite('0, 8'h60);
    doWrite('0, 8'hFF);
    doRead('0, v); check("R9 unlock abort status", v, 8'hB0);
    doWrite('0, 8'h50);
    doWrite('0, 8'h90);
    doRead(6'h22, v); check("R9 locks kept after abort", v, 8'h01);
  endtask

  task automatic testLockdown();
    logic [7:0] v;
    masterLock = 1'b1;
    doWrite('0, 8'h60);
    doWrite('0, 8'hD0);
    doRead('0, v); check("R8 lockdown refuses release", v, 8'h82);
    masterLock = 1'b0;
    doWrite('0, 8'h50);
    doWrite('0, 8'h90);
    doRead(6'h22, v); check("R8 block2 still protected", v, 8'h01);
  endtask

  task automatic testUnlock();
    logic [7:0] v;
    doWrite('0, 8'h60);
    doWrite('0, 8'hD0);
    doRead('0, v); check("R4 busy right after confirm", v, 8'h00);
    doWrite('0, 8'hFF);
    waitReady("R4 ready after busy");
    doRead(6'h05, v); check("R12 mode write ignored while busy", v, 8'h80);
    doWrite('0, 8'h90);
    doRead(6'h22, v); check("R8 block2 released", v, 8'h00);
    doRead(6'h32, v); check("R8 block3 released", v, 8'h00);
  endtask

  task automatic testProgram();
    logic [7:0] v;
    doWrite(6'h05, 8'h40);
    doWrite(6'h05, 8'hA5);
    waitReady("R7 program completes");
    doRead('0, v); check("R7 status clean", v, 8'h80);
    doWrite('0, 8'hFF);
    doRead(6'h05, v); check("R7 first program", v, 8'hA5);
    doWrite(6'h05, 8'h40);
    doWrite(6'h05, 8'h3C);
    waitReady("R7 second program completes");
    doWrite('0, 8'hFF);
    doRead(6'h05, v); check("R7 program ANDs", v, 8'h24);
    doRead(6'h06, v); check("R7 neighbour untouched", v, 8'hFF);
  endtask

  task automatic testErase();
    logic [7:0] v;
    doWrite(6'h15, 8'h40);
    doWrite(6'h15, 8'h00);
    waitReady("R6 setup program completes");
    doWrite(6'h07, 8'h20);
    doWrite(6'h07, 8'hD0);
    waitReady("R6 erase completes");
    doWrite('0, 8'hFF);
    doRead(6'h05, v); check("R6 block0 erased", v, 8'hFF);
    doRead(6'h15, v); check("R6 block1 untouched", v, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdent();
    testProtected();
    testAbort();
    testLockdown();
    testUnlock();
    testProgram();
    testErase();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule